// File: doc/BRIEF.md
# Suspend Wake-up Sequencer

This block takes a device into a low-power suspend state and brings it back out in a fixed order. While the device runs, a suspend request in one clock cycle removes the awake indication, holds the I/O, and locks writes to clocked storage, all at the same clock edge.

Wake-up starts either when the suspend request drops, or, in pin-wake mode, when any enabled pin of an 8-bit wake-pin bank is high. The bank is gated by a programmable enable mask. Once wake-up starts, the sequencer can first issue a one-cycle global set/reset pulse. It then raises the awake indication. After that it releases the I/O hold and the write lock, each at its own programmable number of cycles after awake rises.

The awake indication leaves the block as data plus output-enable. The mode input selects whether it is actively driven both ways or driven only low, with an external pull-up supplying the high level.

Top module: `suspend_wake_seq`

## Requirements
- R1: After reset the device is running: the awake level is high, `io_hold`, `wr_protect` and `gsr_pulse` are 0.
- R2: When `suspend_req` is sampled high while running, the next cycle shows the awake level low and both `io_hold` and `wr_protect` at 1. While the awake level is low, both stay at 1.
- R3: With `cfg_pin_wake_en` = 0, wake-up starts at the first edge where `suspend_req` is sampled low while suspended. The wake pins have no effect.
- R4: With `cfg_pin_wake_en` = 1, wake-up starts at the first edge where `wake_pins[i] & cfg_wake_mask[i]` is 1 for some i. Bit i of the mask enables pin i. `suspend_req` is then not a wake source.
- R5: With `cfg_reset_on_wake` = 1, `gsr_pulse` is high for exactly the one cycle after wake-up starts. The awake level rises in the cycle after that.
- R6: With `cfg_reset_on_wake` = 0, no `gsr_pulse` is issued, and the awake level rises in the cycle after wake-up starts.
- R7: `io_hold` falls exactly N_io cycles after the awake level rises, where N_io is the effective value of `cfg_io_release_cnt`.
- R8: `wr_protect` falls exactly N_wr cycles after the awake level rises, where N_wr is the effective value of `cfg_wr_release_cnt`.
- R9: A programmed count of 0 acts as 1. A programmed count above 1024 acts as 1024.
- R10: A suspend request during the release count is held off: both releases happen on schedule, and the awake level drops in the cycle after the later release.
- R11: With `cfg_awake_push_pull` = 0, `awake_o` is always 0 and `awake_oe` is 1 exactly while the awake level is low. With `cfg_awake_push_pull` = 1, `awake_oe` is 1 and `awake_o` equals the awake level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend_req | input | 1 | Suspend request |
| wake_pins | input | 8 | Wake-pin bank |
| cfg_wake_mask | input | 8 | Per-pin wake enable, bit i for pin i |
| cfg_pin_wake_en | input | 1 | 1 selects pin-bank wake, 0 selects request-drop wake |
| cfg_reset_on_wake | input | 1 | 1 issues a global set/reset pulse on wake |
| cfg_awake_push_pull | input | 1 | 1 drives awake both ways, 0 drives only low |
| cfg_io_release_cnt | input | 11 | Cycles from awake rise to I/O release |
| cfg_wr_release_cnt | input | 11 | Cycles from awake rise to write release |
| awake_o | output | 1 | Awake pad data |
| awake_oe | output | 1 | Awake pad output enable |
| gsr_pulse | output | 1 | One-cycle global set/reset pulse |
| io_hold | output | 1 | I/O held in suspend state while 1 |
| wr_protect | output | 1 | Clocked storage write-locked while 1 |

## Verification
A wrong phase shows at the pads within one cycle. A stuck sleep state keeps awake low after a valid wake source, and a missed suspend leaves `io_hold` low one cycle after the request. A release counter that is off by one, or a clamp that is computed wrongly, moves the falling edge of `io_hold` or `wr_protect` by that many cycles. So every wake sequence is timed from the awake rise and also compared against a cycle-level reference model, which catches any divergence on the clock where it first appears. Mask decoding errors show up as waking from a disabled pin, or as failing to wake from an enabled one.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_SLEEP = 2'd1,
    PH_GSR   = 2'd2,
    PH_COUNT = 2'd3
  } swk_phase_e;
endpackage

// File: rtl/swk_wake_detect.sv
module swk_wake_detect #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] mask,
  input  logic             pin_mode,
  input  logic             suspend_req,
  output logic             wake_evt
);
  logic [NPINS-1:0] pin_hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_hit[i] = pins[i] & mask[i];
  end

  // Pin mode ignores the request; request mode ignores the pins.
  assign wake_evt = pin_mode ? (|pin_hit) : ~suspend_req;
endmodule

// File: rtl/swk_release_timer.sv
module swk_release_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_set,
  input  logic          start,
  input  logic          run,
  input  logic [CW-1:0] cfg_io,
  input  logic [CW-1:0] cfg_wr,
  output logic          io_hold,
  output logic          wr_protect,
  output logic          all_done,
  output logic          io_rel_evt,
  output logic          wr_rel_evt
);
  localparam logic [CW-1:0] MAXC = CW'(1) << (CW - 1);

  function automatic logic [CW-1:0] eff_cnt(input logic [CW-1:0] v);
    if (v == '0)  return CW'(1);
    if (v > MAXC) return MAXC;
    return v;
  endfunction

  logic [CW-1:0] cnt, n_io, n_wr, n_last;

  assign n_io       = eff_cnt(cfg_io);
  assign n_wr       = eff_cnt(cfg_wr);
  assign n_last     = (n_io > n_wr) ? n_io : n_wr;
  assign io_rel_evt = run && (cnt == n_io);
  assign wr_rel_evt = run && (cnt == n_wr);
  assign all_done   = run && (cnt >= n_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      io_hold    <= 1'b0;
      wr_protect <= 1'b0;
    end else begin
      if (start)    cnt <= CW'(1);
      else if (run) cnt <= cnt + CW'(1);
      if (hold_set) begin
        io_hold    <= 1'b1;
        wr_protect <= 1'b1;
      end else begin
        if (io_rel_evt) io_hold    <= 1'b0;
        if (wr_rel_evt) wr_protect <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swk_awake_pad.sv
module swk_awake_pad (
  input  logic level,
  input  logic push_pull,
  output logic pad_o,
  output logic pad_oe
);
  always_comb begin
    if (push_pull) begin
      pad_o  = level;
      pad_oe = 1'b1;
    end else begin
      pad_o  = 1'b0;
      pad_oe = ~level;
    end
  end
endmodule

// File: rtl/suspend_wake_seq.sv
module suspend_wake_seq #(
  parameter int NPINS = 8,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suspend_req,
  input  logic [NPINS-1:0] wake_pins,
  input  logic [NPINS-1:0] cfg_wake_mask,
  input  logic             cfg_pin_wake_en,
  input  logic             cfg_reset_on_wake,
  input  logic             cfg_awake_push_pull,
  input  logic [CNT_W-1:0] cfg_io_release_cnt,
  input  logic [CNT_W-1:0] cfg_wr_release_cnt,
  output logic             awake_o,
  output logic             awake_oe,
  output logic             gsr_pulse,
  output logic             io_hold,
  output logic             wr_protect
);
  import swk_pkg::*;

  swk_phase_e phase;
  logic awake_lvl;
  logic wake_evt, all_done, io_rel_evt, wr_rel_evt;
  logic in_run, sleeping, hold_set, enter_count, in_count;

  assign in_run      = (phase == PH_RUN);
  assign sleeping    = (phase == PH_SLEEP);
  assign in_count    = (phase == PH_COUNT);
  assign hold_set    = in_run && suspend_req;
  assign enter_count = (sleeping && wake_evt && !cfg_reset_on_wake) || (phase == PH_GSR);

  swk_wake_detect #(.NPINS(NPINS)) u_wake (
    .pins(wake_pins), .mask(cfg_wake_mask), .pin_mode(cfg_pin_wake_en),
    .suspend_req(suspend_req), .wake_evt(wake_evt)
  );

  swk_release_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_set(hold_set), .start(enter_count),
    .run(in_count), .cfg_io(cfg_io_release_cnt), .cfg_wr(cfg_wr_release_cnt),
    .io_hold(io_hold), .wr_protect(wr_protect), .all_done(all_done),
    .io_rel_evt(io_rel_evt), .wr_rel_evt(wr_rel_evt)
  );

  swk_awake_pad u_pad (
    .level(awake_lvl), .push_pull(cfg_awake_push_pull),
    .pad_o(awake_o), .pad_oe(awake_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RUN;
      awake_lvl <= 1'b1;
      gsr_pulse <= 1'b0;
    end else begin
      case (phase)
        PH_RUN: if (suspend_req) begin
          phase     <= PH_SLEEP;
          awake_lvl <= 1'b0;
        end
        PH_SLEEP: if (wake_evt) begin
          if (cfg_reset_on_wake) begin
            phase     <= PH_GSR;
            gsr_pulse <= 1'b1;
          end else begin
            phase     <= PH_COUNT;
            awake_lvl <= 1'b1;
          end
        end
        PH_GSR: begin
          gsr_pulse <= 1'b0;
          awake_lvl <= 1'b1;
          phase     <= PH_COUNT;
        end
        PH_COUNT: if (all_done) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/swk_checker.sv
module swk_checker (
  input logic clk,
  input logic rst_n,
  input logic suspend_req,
  input logic cfg_reset_on_wake,
  input logic cfg_awake_push_pull,
  input logic awake_o,
  input logic awake_oe,
  input logic gsr_pulse,
  input logic io_hold,
  input logic wr_protect,
  input logic awake_lvl,
  input logic in_run,
  input logic sleeping,
  input logic wake_evt
);
  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && suspend_req) |=> (!awake_lvl && io_hold && wr_protect));
  // R2
  asleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awake_lvl |-> (io_hold && wr_protect));
  // R5
  gsr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gsr_pulse |=> (!gsr_pulse && awake_lvl));
  // R6
  gsr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gsr_pulse) |-> $past(cfg_reset_on_wake));
  // R4
  stay_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !wake_evt) |=> (!awake_lvl && !gsr_pulse));
  // R7
  io_after_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_hold) |-> awake_lvl);
  // R10
  no_early_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_lvl && (io_hold || wr_protect)) |=> awake_lvl);
  // R11
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_awake_push_pull |-> (!awake_o && (awake_oe != awake_lvl)));
endmodule

bind suspend_wake_seq swk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req),
  .cfg_reset_on_wake(cfg_reset_on_wake), .cfg_awake_push_pull(cfg_awake_push_pull),
  .awake_o(awake_o), .awake_oe(awake_oe), .gsr_pulse(gsr_pulse),
  .io_hold(io_hold), .wr_protect(wr_protect), .awake_lvl(awake_lvl),
  .in_run(in_run), .sleeping(sleeping), .wake_evt(wake_evt)
);

// File: tb/suspend_wake_seq_bench.sv
`timescale 1ns/1ps
module suspend_wake_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic suspend_req = 1'b0;
  logic [7:0] wake_pins = '0, cfg_wake_mask = '0;
  logic cfg_pin_wake_en = 1'b0, cfg_reset_on_wake = 1'b0, cfg_awake_push_pull = 1'b1;
  logic [10:0] cfg_io_release_cnt = 11'd4, cfg_wr_release_cnt = 11'd5;
  logic awake_o, awake_oe, gsr_pulse, io_hold, wr_protect;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  suspend_wake_seq u_suspend_wake_seq (.*);

  function automatic int eff(input int v);
    if (v == 0) return 1;
    if (v > 1024) return 1024;
    return v;
  endfunction

  function automatic logic lvl();
    return cfg_awake_push_pull ? awake_o : ~awake_oe;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: phase 0 run, 1 asleep, 2 reset pulse, 3 counting.
  int mph = 0, mt = 0;
  bit m_awake = 1, m_io = 0, m_wr = 0, m_gsr = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mt = 0; m_awake = 1; m_io = 0; m_wr = 0; m_gsr = 0;
    end else begin
      case (mph)
        0: if (suspend_req) begin mph = 1; m_awake = 0; m_io = 1; m_wr = 1; end
        1: if (cfg_pin_wake_en ? ((wake_pins & cfg_wake_mask) != 0) : !suspend_req) begin
             if (cfg_reset_on_wake) begin mph = 2; m_gsr = 1; end
             else begin mph = 3; m_awake = 1; mt = 0; end
           end
        2: begin m_gsr = 0; m_awake = 1; mph = 3; mt = 0; end
        default: begin
          mt++;
          if (mt >= eff(cfg_io_release_cnt)) m_io = 0;
          if (mt >= eff(cfg_wr_release_cnt)) m_wr = 0;
          if (mt >= eff(cfg_io_release_cnt) && mt >= eff(cfg_wr_release_cnt)) mph = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [4:0] exp_v, act_v;
      exp_v = {cfg_awake_push_pull ? m_awake : 1'b0,
               cfg_awake_push_pull ? 1'b1 : ~m_awake, m_gsr, m_io, m_wr};
      act_v = {awake_o, awake_oe, gsr_pulse, io_hold, wr_protect};
      chk("R7 model", act_v, exp_v);
    end
  end

  task automatic enter_sleep();
    @(negedge clk) suspend_req = 1'b1;
    @(negedge clk);
    chk("R2 awake low", lvl(), 0);
    chk("R2 holds set", {io_hold, wr_protect}, 3);
  endtask

  // Trigger is applied at the current negedge; c=1 is the negedge after that edge.
  task automatic run_wake(input int resusp_at, output int ta, output int tio,
                          output int twr, output int tg, output int tfall);
    ta = -1; tio = -1; twr = -1; tg = -1; tfall = -1;
    for (int c = 1; c < 2200; c++) begin
      @(negedge clk);
      if (gsr_pulse && tg < 0) tg = c;
      if (lvl() && ta < 0) ta = c;
      if (ta > 0 && !io_hold && tio < 0) tio = c;
      if (ta > 0 && !wr_protect && twr < 0) twr = c;
      if (ta > 0 && !lvl() && tfall < 0) tfall = c;
      if (c == resusp_at) suspend_req = 1'b1;
      if (twr > 0 && tio > 0 && c > twr + 2) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ta, tio, twr, tg, tf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 awake after reset", lvl(), 1);
    chk("R1 outputs after reset", {gsr_pulse, io_hold, wr_protect}, 0);

    // Request-drop wake, no reset pulse, counts 4/5.
    enter_sleep();
    wake_pins = 8'hFF; cfg_wake_mask = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R3 pins ignored", lvl(), 0);
    suspend_req = 1'b0;
    run_wake(0, ta, tio, twr, tg, tf);
    chk("R6 awake next cycle", ta, 1);
    chk("R6 no reset pulse", tg, -1);
    chk("R7 io release 4", tio - ta, 4);
    chk("R8 wr release 5", twr - ta, 5);
    wake_pins = '0;

    // Reset pulse, open drain, counts 1/1.
    cfg_awake_push_pull = 1'b0; cfg_reset_on_wake = 1'b1;
    cfg_io_release_cnt = 11'd1; cfg_wr_release_cnt = 11'd1;
    enter_sleep();
    chk("R11 od drives low", {awake_o, awake_oe}, 1);
    suspend_req = 1'b0;
    run_wake(0, ta, tio, twr, tg, tf);
    chk("R5 pulse first", tg, 1);
    chk("R5 awake after pulse", ta, 2);
    chk("R7 io release 1", tio - ta, 1);
    chk("R8 wr release 1", twr - ta, 1);
    chk("R11 od released", {awake_o, awake_oe}, 0);

    // Pin wake with mask 0x0F.
    cfg_awake_push_pull = 1'b1; cfg_reset_on_wake = 1'b0;
    cfg_pin_wake_en = 1'b1; cfg_wake_mask = 8'h0F;
    cfg_io_release_cnt = 11'd2; cfg_wr_release_cnt = 11'd3;
    enter_sleep();
    suspend_req = 1'b0; wake_pins = 8'h20;
    repeat (4) @(negedge clk);
    chk("R4 masked pin and request drop ignored", lvl(), 0);
    wake_pins = 8'h04;
    run_wake(0, ta, tio, twr, tg, tf);
    chk("R4 enabled pin wakes", ta, 1);
    chk("R7 io release 2", tio - ta, 2);
    chk("R8 wr release 3", twr - ta, 3);
    wake_pins = '0; cfg_pin_wake_en = 1'b0;

    // Clamping of count values.
    cfg_io_release_cnt = 11'd0; cfg_wr_release_cnt = 11'd2000;
    enter_sleep();
    suspend_req = 1'b0;
    run_wake(0, ta, tio, twr, tg, tf);
    chk("R9 zero acts as one", tio - ta, 1);
    chk("R9 large acts as 1024", twr - ta, 1024);

    // Suspend request during the count is held off.
    cfg_io_release_cnt = 11'd3; cfg_wr_release_cnt = 11'd6;
    enter_sleep();
    suspend_req = 1'b0;
    run_wake(2, ta, tio, twr, tg, tf);
    chk("R10 io on schedule", tio - ta, 3);
    chk("R10 wr on schedule", twr - ta, 6);
    chk("R10 sleep after last release", tf, twr + 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule